// File: doc/BRIEF.md
# Bus Master Transaction Sequencer with Response Timeout

This block runs one master-side exchange on a shared half-duplex serial bus at a time. A requester hands it a command byte and a target station number. The block starts the line transmitter and keeps its drive-enable high until the transmitter signals that the last half-bit has gone out. It then releases the line and opens a fixed turnaround window, so that the addressed station can reply.

A start-sequence detection from the receiver inside the window cancels the timeout. The block then waits for the receiver to report end-of-message or a parity or framing error. A second, longer guard timer ends a reception that never finishes. Each transaction closes with exactly one single-cycle report that carries a status code. Station number 7 is reserved on the bus as the end-of-transmission marker, so a request aimed at it is refused at once and nothing is sent.

The window length (default 640 cycles, 80 µs at 8 MHz) and the guard length are parameters. Only the master may begin an exchange. Stations speak only in reply, so the block never has to arbitrate.

Top module: `poll_txn_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `tx_start`, `tx_active`, `rx_enable` and `rsp_valid` are all 0.
- R2: A request with `req_addr` from 0 to 6, seen while `req_ready` is 1, makes `tx_start` high for exactly the following cycle. In that cycle `tx_addr` and `tx_cmd` carry the request values, and `tx_active` stays high until `tx_done` is seen.
- R3: A request with `req_addr` = 7 raises no `tx_start`. In the next cycle it produces `rsp_valid` with `rsp_status` = 4 (bad address).
- R4: The cycle after `tx_done` is seen, `tx_active` is 0 and `rx_enable` is 1. The line is released before the window opens.
- R5: If `rx_start_det` is not seen in any of the WINDOW_CYC cycles after release, `rsp_valid` rises in the next cycle with `rsp_status` = 1 (timeout).
- R6: An `rx_start_det` in any window cycle, the last one included, cancels the timeout. `rx_enable` stays high and no report is made until the receiver ends the message. Outside the window and reception, `rx_start_det`, `rx_eom` and both error inputs have no effect.
- R7: During reception, `rx_eom` reports status 0 (OK), `rx_parity_err` reports 2 and `rx_frame_err` reports 3. When several are high in the same cycle, a framing error wins over a parity error, and a parity error wins over end-of-message.
- R8: If reception has not ended GUARD_CYC cycles after start detection, the block reports status 5 (reception overrun).
- R9: `rsp_valid` is a single-cycle pulse, and `req_ready` is 1 again in the cycle after it. Requests presented while `req_ready` is 0 are ignored: they cause neither a transmission nor a report, and they do not change `tx_addr` or `tx_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 3 | Target station, 0..6 legal |
| req_cmd | input | 8 | Command byte to send |
| req_ready | output | 1 | Idle, request accepted this cycle |
| tx_start | output | 1 | One-cycle start pulse to transmitter |
| tx_addr | output | 3 | Station for the transmitter |
| tx_cmd | output | 8 | Command for the transmitter |
| tx_active | output | 1 | Line drive enable |
| tx_done | input | 1 | Last half-bit has been sent |
| rx_enable | output | 1 | Receiver listening (window or reception) |
| rx_start_det | input | 1 | Start sequence detected |
| rx_eom | input | 1 | End-of-message frame received |
| rx_parity_err | input | 1 | Receiver parity error |
| rx_frame_err | input | 1 | Receiver framing error |
| rsp_valid | output | 1 | Transaction report pulse |
| rsp_status | output | 3 | 0 OK, 1 timeout, 2 parity, 3 framing, 4 bad address, 5 overrun |

## Verification
A wrong state shows at the ports within one cycle. A stuck drive-enable overlaps `rx_enable`. A missed transition leaves `req_ready` low or produces a report without a preceding window. Off-by-one counter faults show as a timeout report one cycle early or late, or as a start pulse in the final window cycle failing to cancel it. Priority and encoding faults show in the `rsp_status` value of the single report pulse.

// File: rtl/poll_txn_ctrl.sv
module poll_txn_ctrl #(
  parameter int WINDOW_CYC = 640,
  parameter int GUARD_CYC  = 34000,
  parameter int ADDR_W     = 3,
  parameter int CMD_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  output logic              req_ready,
  output logic              tx_start,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [CMD_W-1:0]  tx_cmd,
  output logic              tx_active,
  input  logic              tx_done,
  output logic              rx_enable,
  input  logic              rx_start_det,
  input  logic              rx_eom,
  input  logic              rx_parity_err,
  input  logic              rx_frame_err,
  output logic              rsp_valid,
  output logic [2:0]        rsp_status
);
  localparam int CNT_MAX = (GUARD_CYC > WINDOW_CYC) ? GUARD_CYC : WINDOW_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0]  WIN_LAST   = CNT_W'(WINDOW_CYC - 1);
  localparam logic [CNT_W-1:0]  GUARD_LAST = CNT_W'(GUARD_CYC - 1);
  localparam logic [ADDR_W-1:0] EOT_ADDR   = '1;

  localparam logic [2:0] ST_OK      = 3'd0;
  localparam logic [2:0] ST_TIMEOUT = 3'd1;
  localparam logic [2:0] ST_PARITY  = 3'd2;
  localparam logic [2:0] ST_FRAMING = 3'd3;
  localparam logic [2:0] ST_BADADDR = 3'd4;
  localparam logic [2:0] ST_OVERRUN = 3'd5;

  typedef enum logic [2:0] {IDLE, SEND, WAIT_RESP, RECEIVE, REPORT} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        status_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE;
      cnt      <= '0;
      status_q <= ST_OK;
      addr_q   <= '0;
      cmd_q    <= '0;
      tx_start <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      case (state)
        IDLE: if (req_valid) begin
          if (req_addr == EOT_ADDR) begin
            status_q <= ST_BADADDR;
            state    <= REPORT;
          end else begin
            addr_q   <= req_addr;
            cmd_q    <= req_cmd;
            tx_start <= 1'b1;
            state    <= SEND;
          end
        end
        SEND: if (tx_done) begin
          cnt   <= '0;
          state <= WAIT_RESP;
        end
        WAIT_RESP: begin
          if (rx_start_det) begin
            cnt   <= '0;
            state <= RECEIVE;
          end else if (cnt == WIN_LAST) begin
            status_q <= ST_TIMEOUT;
            state    <= REPORT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RECEIVE: begin
          if (rx_frame_err) begin
            status_q <= ST_FRAMING;
            state    <= REPORT;
          end else if (rx_parity_err) begin
            status_q <= ST_PARITY;
            state    <= REPORT;
          end else if (rx_eom) begin
            status_q <= ST_OK;
            state    <= REPORT;
          end else if (cnt == GUARD_LAST) begin
            status_q <= ST_OVERRUN;
            state    <= REPORT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        REPORT:  state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  assign req_ready  = (state == IDLE);
  assign tx_active  = (state == SEND);
  assign rx_enable  = (state == WAIT_RESP) || (state == RECEIVE);
  assign rsp_valid  = (state == REPORT);
  assign rsp_status = status_q;
  assign tx_addr    = addr_q;
  assign tx_cmd     = cmd_q;
endmodule

// File: rtl/poll_txn_ctrl_chk.sv
module poll_txn_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_addr,
  input logic       req_ready,
  input logic       tx_start,
  input logic [2:0] tx_addr,
  input logic       tx_active,
  input logic       tx_done,
  input logic       rx_enable,
  input logic       rsp_valid,
  input logic [2:0] rsp_status
);
  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(req_valid && req_ready && req_addr != 3'd7));

  // R2
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tx_addr != 3'd7 && tx_active));

  // R3
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr == 3'd7) |=> (rsp_valid && rsp_status == 3'd4 && !tx_start));

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && tx_done) |=> (!tx_active && rx_enable));

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_active && rx_enable));

  // R9
  single_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active || rx_enable || rsp_valid) |-> !req_ready);
endmodule

bind poll_txn_ctrl poll_txn_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_ready(req_ready), .tx_start(tx_start), .tx_addr(tx_addr),
  .tx_active(tx_active), .tx_done(tx_done), .rx_enable(rx_enable),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status)
);

// File: tb/poll_txn_ctrl_bench.sv
module poll_txn_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 20;
  localparam int G = 60;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [2:0] req_addr = 0;
  logic [7:0] req_cmd = 0;
  logic tx_done = 0, rx_start_det = 0, rx_eom = 0, rx_parity_err = 0, rx_frame_err = 0;
  logic req_ready, tx_start, tx_active, rx_enable, rsp_valid;
  logic [2:0] tx_addr, rsp_status;
  logic [7:0] tx_cmd;
  int checks = 0, fails = 0;
  bit done = 0;

  poll_txn_ctrl #(.WINDOW_CYC(W), .GUARD_CYC(G)) u_poll_txn_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_ready(req_ready), .tx_start(tx_start),
    .tx_addr(tx_addr), .tx_cmd(tx_cmd), .tx_active(tx_active), .tx_done(tx_done),
    .rx_enable(rx_enable), .rx_start_det(rx_start_det), .rx_eom(rx_eom),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic begin_txn(input logic [2:0] a, input logic [7:0] c);
    @(negedge clk); req_valid = 1; req_addr = a; req_cmd = c;
    @(negedge clk); req_valid = 0;
    chk("R2 tx_start", int'(tx_start), 1);
    chk("R2 tx_addr", int'(tx_addr), int'(a));
    chk("R2 tx_cmd", int'(tx_cmd), int'(c));
    chk("R2 tx_active", int'(tx_active), 1);
    @(negedge clk);
    chk("R2 tx_start single", int'(tx_start), 0);
  endtask

  task automatic finish_send();
    tx_done = 1;
    @(negedge clk); tx_done = 0;
    chk("R4 tx_active released", int'(tx_active), 0);
    chk("R4 rx_enable", int'(rx_enable), 1);
  endtask

  task automatic wait_rsp(input int limit, output int n);
    n = 1;
    while (!rsp_valid && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic after_report(input string req);
    @(negedge clk);
    chk({req, " rsp pulse single"}, int'(rsp_valid), 0);
    chk({req, " ready again"}, int'(req_ready), 1);
  endtask

  task automatic t_reset();
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 tx_start", int'(tx_start), 0);
    chk("R1 tx_active", int'(tx_active), 0);
    chk("R1 rx_enable", int'(rx_enable), 0);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_timeout();
    int n;
    begin_txn(3'd2, 8'h5A);
    repeat (3) @(negedge clk);
    chk("R2 tx_active held", int'(tx_active), 1);
    finish_send();
    wait_rsp(W + 10, n);
    chk("R5 timeout cycle", n, W + 1);
    chk("R5 timeout status", int'(rsp_status), 1);
    after_report("R9");
  endtask

  task automatic t_bad_addr();
    @(negedge clk); req_valid = 1; req_addr = 3'd7; req_cmd = 8'hFF;
    @(negedge clk); req_valid = 0;
    chk("R3 no tx_start", int'(tx_start), 0);
    chk("R3 rsp_valid", int'(rsp_valid), 1);
    chk("R3 status", int'(rsp_status), 4);
    chk("R3 tx_active", int'(tx_active), 0);
    after_report("R3");
  endtask

  task automatic t_last_cycle_start();
    begin_txn(3'd0, 8'h11);
    finish_send();
    repeat (W - 1) @(negedge clk);
    chk("R6 still waiting", int'(rsp_valid), 0);
    rx_start_det = 1;
    @(negedge clk); rx_start_det = 0;
    chk("R6 no timeout", int'(rsp_valid), 0);
    chk("R6 rx_enable", int'(rx_enable), 1);
    repeat (W + 5) @(negedge clk);
    chk("R6 timeout cancelled", int'(rsp_valid), 0);
    rx_eom = 1;
    @(negedge clk); rx_eom = 0;
    chk("R7 eom report", int'(rsp_valid), 1);
    chk("R7 ok status", int'(rsp_status), 0);
    after_report("R7");
  endtask

  task automatic t_errors(input bit fe, input bit pe, input bit eom, input int exp, input string req);
    begin_txn(3'd6, 8'hC3);
    finish_send();
    repeat (3) @(negedge clk);
    rx_start_det = 1;
    @(negedge clk); rx_start_det = 0;
    repeat (2) @(negedge clk);
    rx_frame_err = fe; rx_parity_err = pe; rx_eom = eom;
    @(negedge clk); rx_frame_err = 0; rx_parity_err = 0; rx_eom = 0;
    chk({req, " report"}, int'(rsp_valid), 1);
    chk({req, " status"}, int'(rsp_status), exp);
    after_report(req);
  endtask

  task automatic t_guard();
    int n;
    begin_txn(3'd4, 8'h80);
    finish_send();
    rx_start_det = 1;
    @(negedge clk); rx_start_det = 0;
    wait_rsp(G + 10, n);
    chk("R8 guard cycle", n, G + 1);
    chk("R8 overrun status", int'(rsp_status), 5);
    after_report("R8");
  endtask

  task automatic t_ignored();
    @(negedge clk); rx_start_det = 1; rx_eom = 1; rx_frame_err = 1;
    @(negedge clk); rx_start_det = 0; rx_eom = 0; rx_frame_err = 0;
    chk("R6 idle rx ignored rsp", int'(rsp_valid), 0);
    chk("R6 idle rx ignored ready", int'(req_ready), 1);
    begin_txn(3'd1, 8'h3C);
    rx_start_det = 1; rx_eom = 1; rx_parity_err = 1;
    req_valid = 1; req_addr = 3'd7; req_cmd = 8'h99;
    @(negedge clk);
    rx_start_det = 0; rx_eom = 0; rx_parity_err = 0; req_valid = 0;
    @(negedge clk);
    chk("R6 send rx ignored", int'(rsp_valid), 0);
    chk("R6 still sending", int'(tx_active), 1);
    chk("R9 busy req no report", int'(rsp_valid), 0);
    chk("R9 tx_addr kept", int'(tx_addr), 1);
    chk("R9 tx_cmd kept", int'(tx_cmd), 8'h3C);
    finish_send();
    rx_start_det = 1;
    @(negedge clk); rx_start_det = 0;
    rx_eom = 1;
    @(negedge clk); rx_eom = 0;
    chk("R7 ok after ignored", int'(rsp_status), 0);
    after_report("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_timeout();
    t_bad_addr();
    t_last_cycle_start();
    t_errors(1, 1, 1, 3, "R7 framing first");
    t_errors(0, 1, 1, 2, "R7 parity over eom");
    t_guard();
    t_ignored();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule